// File: doc/BRIEF.md
# PLL divider coefficient search engine

This engine picks divider settings for a clock synthesizer. Its inputs are a reference frequency and a requested output frequency, both unsigned integers in Hz. It steps through settings of the pre-divider R, the feedback multiplier F and the output shift OD. A setting is a candidate when its VCO frequency lies inside the legal band and its output frequency lies inside a narrow window around the request. Each candidate receives a score, and the engine keeps the best one it has seen. It returns R, F, an encoded post-divider code, the output frequency achieved, a packed 16-bit mode word for the synthesizer, and a flag that says whether any candidate was found.

A request is launched by a one-cycle `start` pulse. `busy` stays high for the whole search and `done` pulses once at the end. The divisions run on one shared serial divider inside the block. A search therefore takes some thousands of cycles. It is meant to run once, when a clock is being configured.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, busy, done and found are 0, and achieved_hz, r_sel, f_sel, post_code and mode_word are all 0.
- R2: The shift values are tried in the order OD=1, then 2, then 0, and for each one R goes from 2 to 33. A candidate must satisfy both of the following: VCO = floor(ref/R)·F lies in [100 000 000, 500 000 000], and the output VCO>>OD lies in [req − (req>>8), req + (req>>8)]. When a result is found, achieved_hz is the output frequency of the chosen candidate.
- R3: The first F tried for each R is floor(R·((req>>8)<<OD) / (ref>>8)), computed in 32 bits and truncated. One is subtracted from it when it is above 2. F then rises one step at a time, and only values from 2 to 513 inclusive are ever tried. f_sel reports the chosen F.
- R4: The score is floor((floor(ref/R) − floor(ref/33)) / ((ref − floor(ref/33))>>10)) + floor((VCO − 100 000 000) / 390 625). The first candidate is always kept. A later candidate replaces the kept one only if its score is greater than or equal to the kept score and its OD is not 0. r_sel reports the chosen R.
- R5: post_code is 3 when the chosen OD is 2 (or 3). Otherwise it equals the chosen OD.
- R6: mode_word[1:0] = post_code, mode_word[10:2] = F−2 and mode_word[15:11] = R−2.
- R7: When no candidate exists, found is 0 at done and achieved_hz is 0. r_sel, f_sel, post_code and mode_word keep the values they had before.
- R8: busy is 1 from the cycle after an accepted start until the cycle in which done is 1. done is high for exactly one cycle.
- R9: A start pulse while busy is 1 is ignored. It changes neither the result nor the length of the running search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch pulse, accepted only when idle |
| ref_hz | input | 32 | Reference frequency in Hz, sampled at start |
| req_hz | input | 32 | Requested output frequency in Hz, sampled at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse; results valid from here on |
| found | output | 1 | A candidate was accepted in the last search |
| r_sel | output | 6 | Chosen pre-divider R |
| f_sel | output | 10 | Chosen feedback multiplier F |
| post_code | output | 2 | Encoded post-divider |
| achieved_hz | output | 32 | Output frequency of the chosen setting, 0 if none |
| mode_word | output | 16 | Packed synthesizer mode word |

## Verification
A search that runs wrong stays hidden until the done pulse. Only then can R, F, the code or the achieved frequency differ from the values the independent model computes. Each search is compared field by field with that model. An error in the seed estimate, the stop conditions or the tie rule makes the engine land on a different setting. A broken visit order, a stale per-R quotient or a wrong phase term shifts the score, so the replacement rule picks another candidate. A divider or FSM that hangs shows up as a missing done pulse within one search time.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_R33_GO,
        ST_R33_WAIT,
        ST_EST_GO,
        ST_EST_WAIT,
        ST_REFR_GO,
        ST_REFR_WAIT,
        ST_PH_GO,
        ST_PH_WAIT,
        ST_STEP,
        ST_VS_GO,
        ST_VS_WAIT
    } srch_st_e;

    // Visit order of the output shift: index 0,1,2 -> shift 1,2,0
    function automatic logic [1:0] od_of(input logic [1:0] idx);
        case (idx)
            2'd0:    od_of = 2'd1;
            2'd1:    od_of = 2'd2;
            default: od_of = 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] post_code_of(input logic [1:0] od);
        post_code_of = (od >= 2'd2) ? 2'd3 : od;
    endfunction

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } div_t;

    div_t q, d;
    logic [W:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.quo[W-1]};
        if (go) begin
            d.run = 1'b1;
            d.cnt = CW'(W);
            d.rem = '0;
            d.quo = num;
            d.den = den;
        end else if (q.run) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = W'(trial - {1'b0, q.den});
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = trial[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

    // The remainder left at completion must be below a non-zero divisor
    AST_DIV_REM: assert property (@(posedge clk) disable iff (!rst_n)
        q.done && (q.den != '0) |-> q.rem < q.den); // R3

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int           W       = 32,
    parameter int           FW      = 10,
    parameter int           F_MIN   = 2,
    parameter int           F_MAX   = 513,
    parameter logic [W-1:0] VCO_MIN = 32'd100_000_000,
    parameter logic [W-1:0] VCO_MAX = 32'd500_000_000
) (
    input  logic [W-1:0]    refr,
    input  logic [W-1:0]    f,
    input  logic [1:0]      od,
    input  logic [W:0]      minc,
    input  logic [W:0]      maxc,
    output logic [W+FW-1:0] vco,
    output logic [W+FW-1:0] out_hz,
    output logic            f_ok,
    output logic            over,
    output logic            hit
);
    localparam int VW = W + FW;

    always_comb begin
        f_ok   = (f >= W'(F_MIN)) && (f <= W'(F_MAX));
        vco    = VW'(refr) * VW'(f[FW-1:0]);
        out_hz = vco >> od;
        // Both VCO and output rise with F: past either limit no later F fits
        over   = (vco > VW'(VCO_MAX)) || (out_hz > VW'(maxc));
        hit    = f_ok && !over && (vco >= VW'(VCO_MIN)) && (out_hz >= VW'(minc));
    end

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pll_search_pkg::*;
#(
    parameter int           W           = 32,
    parameter int           R_MIN       = 2,
    parameter int           R_MAX       = 33,
    parameter int           F_MIN       = 2,
    parameter int           F_MAX       = 513,
    parameter int           PRE_SHIFT   = 8,
    parameter int           SCORE_SHIFT = 10,
    parameter logic [W-1:0] VCO_MIN     = 32'd100_000_000,
    parameter logic [W-1:0] VCO_MAX     = 32'd500_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  ref_hz,
    input  logic [W-1:0]  req_hz,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic [5:0]    r_sel,
    output logic [9:0]    f_sel,
    output logic [1:0]    post_code,
    output logic [W-1:0]  achieved_hz,
    output logic [15:0]   mode_word
);
    localparam int RW      = $clog2(R_MAX + 1);
    localparam int FW      = $clog2(F_MAX + 1);
    localparam int VW      = W + FW;
    localparam int MODE_W  = (RW - 1) + (FW - 1) + 2;
    localparam logic [W-1:0] VSC_DEN = (VCO_MAX - VCO_MIN) >> SCORE_SHIFT;

    typedef struct packed {
        srch_st_e          st;
        logic [W-1:0]      ref_v;
        logic [W-1:0]      req_v;
        logic [W:0]        minc;
        logic [W:0]        maxc;
        logic [W-1:0]      r33;
        logic [W-1:0]      pden;
        logic [W-1:0]      refr;
        logic [W-1:0]      phase;
        logic [W-1:0]      fcur;
        logic [RW-1:0]     r;
        logic [1:0]        oi;
        logic              have;
        logic [W-1:0]      best_score;
        logic [W-1:0]      best_clk;
        logic [RW-1:0]     best_r;
        logic [FW-1:0]     best_f;
        logic [1:0]        best_od;
        logic              done;
        logic              found;
        logic [RW-1:0]     r_o;
        logic [FW-1:0]     f_o;
        logic [1:0]        code_o;
        logic [MODE_W-1:0] mode_o;
        logic [W-1:0]      clk_o;
    } srch_t;

    srch_t q, d;

    logic          div_go, div_done;
    logic [W-1:0]  div_num, div_den, div_q;
    logic [VW-1:0] vco, out_hz;
    logic          f_ok, over, hit, adv_r;
    logic [1:0]    cur_od, code_n;
    logic [W-1:0]  score;
    logic [RW-1:0] r_m;
    logic [FW-1:0] f_m;

    pll_div_seq #(.W(W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_q)
    );

    pll_cand_eval #(
        .W(W), .FW(FW), .F_MIN(F_MIN), .F_MAX(F_MAX),
        .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
    ) u_eval (
        .refr  (q.refr),
        .f     (q.fcur),
        .od    (cur_od),
        .minc  (q.minc),
        .maxc  (q.maxc),
        .vco   (vco),
        .out_hz(out_hz),
        .f_ok  (f_ok),
        .over  (over),
        .hit   (hit)
    );

    // Shared divider: operands chosen by the issuing state
    always_comb begin
        cur_od  = od_of(q.oi);
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        case (q.st)
            ST_R33_GO: begin
                div_go  = 1'b1;
                div_num = q.ref_v;
                div_den = W'(R_MAX);
            end
            ST_EST_GO: begin
                div_go  = 1'b1;
                div_num = W'(q.r) * ((q.req_v >> PRE_SHIFT) << cur_od);
                div_den = q.ref_v >> PRE_SHIFT;
            end
            ST_REFR_GO: begin
                div_go  = 1'b1;
                div_num = q.ref_v;
                div_den = W'(q.r);
            end
            ST_PH_GO: begin
                div_go  = 1'b1;
                div_num = q.refr - q.r33;
                div_den = q.pden;
            end
            ST_VS_GO: begin
                div_go  = 1'b1;
                div_num = W'(vco - VW'(VCO_MIN));
                div_den = VSC_DEN;
            end
            default: ;
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        adv_r  = 1'b0;
        score  = q.phase + div_q;
        code_n = post_code_of(q.best_od);
        r_m    = q.best_r - RW'(R_MIN);
        f_m    = q.best_f - FW'(F_MIN);
        case (q.st)
            ST_IDLE: if (start) begin
                d.ref_v = ref_hz;
                d.req_v = req_hz;
                d.minc  = {1'b0, req_hz} - {1'b0, req_hz >> PRE_SHIFT};
                d.maxc  = {1'b0, req_hz} + {1'b0, req_hz >> PRE_SHIFT};
                d.have  = 1'b0;
                d.st    = ST_R33_GO;
            end
            ST_R33_GO:  d.st = ST_R33_WAIT;
            ST_R33_WAIT: if (div_done) begin
                d.r33  = div_q;
                d.pden = (q.ref_v - div_q) >> SCORE_SHIFT;
                d.r    = RW'(R_MIN);
                d.oi   = 2'd0;
                d.st   = ST_EST_GO;
            end
            ST_EST_GO:  d.st = ST_EST_WAIT;
            ST_EST_WAIT: if (div_done) begin
                d.fcur = (div_q > W'(F_MIN)) ? div_q - 1'b1 : div_q;
                d.st   = ST_REFR_GO;
            end
            ST_REFR_GO: d.st = ST_REFR_WAIT;
            ST_REFR_WAIT: if (div_done) begin
                d.refr = div_q;
                d.st   = ST_PH_GO;
            end
            ST_PH_GO:   d.st = ST_PH_WAIT;
            ST_PH_WAIT: if (div_done) begin
                d.phase = div_q;
                d.st    = ST_STEP;
            end
            ST_STEP: begin
                if (!f_ok || over)  adv_r  = 1'b1;
                else if (hit)       d.st   = ST_VS_GO;
                else                d.fcur = q.fcur + 1'b1;
            end
            ST_VS_GO:   d.st = ST_VS_WAIT;
            ST_VS_WAIT: if (div_done) begin
                if (!q.have || ((score >= q.best_score) && (cur_od != 2'd0))) begin
                    d.have       = 1'b1;
                    d.best_score = score;
                    d.best_clk   = out_hz[W-1:0];
                    d.best_r     = q.r;
                    d.best_f     = q.fcur[FW-1:0];
                    d.best_od    = cur_od;
                end
                d.fcur = q.fcur + 1'b1;
                d.st   = ST_STEP;
            end
            default: d.st = ST_IDLE;
        endcase

        if (adv_r) begin
            if (q.r != RW'(R_MAX)) begin
                d.r  = q.r + 1'b1;
                d.st = ST_EST_GO;
            end else if (q.oi != 2'd2) begin
                d.oi = q.oi + 1'b1;
                d.r  = RW'(R_MIN);
                d.st = ST_EST_GO;
            end else begin
                d.st    = ST_IDLE;
                d.done  = 1'b1;
                d.found = q.have;
                if (q.have) begin
                    d.r_o    = q.best_r;
                    d.f_o    = q.best_f;
                    d.code_o = code_n;
                    d.mode_o = {r_m[RW-2:0], f_m[FW-2:0], code_n};
                    d.clk_o  = q.best_clk;
                end else begin
                    d.clk_o  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
    assign found       = q.found;
    assign r_sel       = 6'(q.r_o);
    assign f_sel       = 10'(q.f_o);
    assign post_code   = q.code_o;
    assign achieved_hz = q.clk_o;
    assign mode_word   = 16'(q.mode_o);

    AST_FOUND_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> ({1'b0, achieved_hz} >= q.minc) && ({1'b0, achieved_hz} <= q.maxc)); // R2
    AST_F_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> (f_sel >= 10'(F_MIN)) && (f_sel <= 10'(F_MAX))); // R3
    AST_CODE_NO_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> post_code != 2'd2); // R5
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !found |-> achieved_hz == '0); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(q.ref_v) && $stable(q.req_v)); // R9

endmodule

// File: tb/tb_pll_coef_search.sv
module tb_pll_coef_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0, req_hz = '0;
    logic        busy, done, found;
    logic [5:0]  r_sel;
    logic [9:0]  f_sel;
    logic [1:0]  post_code;
    logic [31:0] achieved_hz;
    logic [15:0] mode_word;

    int checks = 0;
    int failures = 0;

    typedef struct {
        longint found, hz, r, f, code, mode;
    } exp_t;

    exp_t sb_q[$];
    exp_t last;

    always #5 clk = ~clk;

    pll_coef_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .req_hz(req_hz),
        .busy(busy), .done(done), .found(found), .r_sel(r_sel), .f_sel(f_sel),
        .post_code(post_code), .achieved_hz(achieved_hz), .mode_word(mode_word)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Search model built from the requirements, full F sweep
    function automatic exp_t model(input longint rf, input longint rq, input exp_t prev);
        exp_t   e;
        longint minc, maxc, r33, pden, num, den, f, refr, ph, vco, o, sc;
        longint best_sc, b_r, b_f, b_od, b_hz;
        bit     have;
        minc = rq - (rq >> 8);
        maxc = rq + (rq >> 8);
        r33  = rf / 33;
        pden = (rf - r33) >> 10;
        have = 0;
        best_sc = 0; b_r = 0; b_f = 0; b_od = 0; b_hz = 0;
        for (int oi = 0; oi < 3; oi++) begin
            longint od;
            od = (oi == 0) ? 1 : ((oi == 1) ? 2 : 0);
            for (int r = 2; r <= 33; r++) begin
                num  = (longint'(r) * ((rq >> 8) << od)) & 64'hFFFF_FFFF;
                den  = rf >> 8;
                f    = (den == 0) ? 64'hFFFF_FFFF : num / den;
                if (f > 2) f--;
                refr = rf / r;
                ph   = (pden == 0) ? 64'hFFFF_FFFF : (refr - r33) / pden;
                while (f >= 2 && f <= 513) begin
                    vco = refr * f;
                    if (vco >= 100_000_000 && vco <= 500_000_000) begin
                        o = vco >> od;
                        if (o >= minc && o <= maxc) begin
                            sc = (ph + (vco - 100_000_000) / 390_625) & 64'hFFFF_FFFF;
                            if (!have || (sc >= best_sc && od != 0)) begin
                                have = 1; best_sc = sc; b_r = r; b_f = f; b_od = od; b_hz = o;
                            end
                        end
                    end
                    f++;
                end
            end
        end
        if (have) begin
            e.found = 1;
            e.hz    = b_hz;
            e.r     = b_r;
            e.f     = b_f;
            e.code  = (b_od >= 2) ? 3 : b_od;
            e.mode  = ((b_r - 2) << 11) | ((b_f - 2) << 2) | e.code;
        end else begin
            e       = prev;
            e.found = 0;
            e.hz    = 0;
        end
        return e;
    endfunction

    task automatic run_case(input longint rf, input longint rq, input bit poke);
        exp_t e;
        e = model(rf, rq, last);
        last = e;
        sb_q.push_back(e);
        @(negedge clk);
        start  = 1'b1;
        ref_hz = 32'(rf);
        req_hz = 32'(rq);
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", longint'(busy), 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            start  = 1'b1;
            ref_hz = 32'(rf + 12345);
            req_hz = 32'(rq / 2);
            @(negedge clk);
            start = 1'b0;
            chk("R9 busy kept after ignored start", longint'(busy), 1);
        end
        while (!done) begin
            if (!busy) chk("R8 busy until done", longint'(busy), 1);
            @(negedge clk);
        end
        @(negedge clk);
        chk("R8 idle after done", longint'(busy), 0);
    endtask

    // Monitor: pops the scoreboard on each done pulse
    bit chk_next = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_next) begin
                chk("R8 done one cycle", longint'(done), 0);
                chk_next = 0;
            end else if (done) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    chk("R9 unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk("R7 found", longint'(found), e.found);
                    chk("R2 achieved_hz", longint'(achieved_hz), e.hz);
                    chk("R4 r_sel", longint'(r_sel), e.r);
                    chk("R3 f_sel", longint'(f_sel), e.f);
                    chk("R5 post_code", longint'(post_code), e.code);
                    chk("R6 mode_word", longint'(mode_word), e.mode);
                end
                chk_next = 1;
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        last = '{default: 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
        chk("R1 found", longint'(found), 0);
        chk("R1 achieved_hz", longint'(achieved_hz), 0);
        chk("R1 r_sel", longint'(r_sel), 0);
        chk("R1 f_sel", longint'(f_sel), 0);
        chk("R1 post_code", longint'(post_code), 0);
        chk("R1 mode_word", longint'(mode_word), 0);

        run_case(14_318_000, 100_000_000, 1'b0);
        run_case(14_318_000, 250_000_000, 1'b1);   // R9 ignored start mid-search
        run_case(27_000_000, 74_250_000, 1'b0);
        run_case(14_318_000, 10_000_000, 1'b0);    // R7 nothing reachable, hold
        run_case(10_000_000, 400_000_000, 1'b0);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", longint'(sb_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule